// File: doc/BRIEF.md
# Wake Event Aggregation Logic

This block sits in the standby-powered part of a power controller. It gathers wake and system-management events and records each in a status bit. It decides when the main supply is requested, and it signals firmware and the operating system. The external inputs are two ring-indicator lines, the keyboard and mouse data lines, a bank of GPIO pins, and an active-low power button. Each of these passes through a two-flop synchronizer before edge detection. Other sources reach it as single-cycle synchronous strobes: a key-match strobe, an RTC alarm, a fan-tachometer event and a standby power-on-reset event. Legacy interrupt sources arrive as level inputs.

Every status bit is cleared by writing a one to it through a 16-bit word-addressed register port. Enable registers select which sources feed an aggregate PME status bit, and which status bits drive the PME output and the SMI or SCI. A mode bit decides whether enabled events raise an SMI or an SCI.

If the power button is held for a long time while the supply is on, the supply is cut and an override lock is set. Under that lock only the button can wake the system. A standby power-on reset re-requests the supply in two cases: when its wake-enable bit is set, or when the supply was on before the reset and the force-off bit is clear. The configuration registers keep their values across that reset. Only a cold reset clears them.

Top module: `wake_event_hub`

## Requirements
- R1: A falling edge on ringN[0], ringN[1], kbdData or mouseData sets status A bit 0, 1, 2 or 3 respectively, and a keyMatch strobe sets bit 4 (status A at address 0).
- R2: GPIO pin i sets status G bit i (address 1) on a rising edge when edge-select bit i (address 4) is 1, and on a falling edge when it is 0; the opposite edge has no effect.
- R3: Status A bit 7 (aggregate) is set only when a source that sets status A bits 4:0 or a GPIO status bit is enabled in the PME-path enable register (address 2): bits 4:0 enable status A bits 4:0, bits 8+i enable GPIO pin i, and unimplemented bits read 0.
- R4: rtcAlarm sets status A bit 8, fanEvent sets bit 9, and neither ever sets the aggregate bit 7, whatever the PME-path enables hold.
- R5: Writing a one to a status bit clears it; writing zero leaves it unchanged.
- R6: pmeN is low, one cycle after the fact, exactly while some status A bit is set whose bit in the output-enable register (address 3, same bit positions as status A, bit 6 not implemented) is set.
- R7: Control register (address 5) bit 0 selects the target of the enabled condition of R6: 0 drives smiOut, 1 drives sciOut.
- R8: A legacy source smiSrc[j] with its enable (control bit 8+j) set drives smiOut, sets no status bit and never requests the supply.
- R9: A falling edge on pwrBtnN sets status A bit 5, and when the supply is off it requests the supply (psOnN low).
- R10: Holding pwrBtnN low for OVR_HOLD cycles while on drops the supply and sets status A bit 6. While bit 6 is set, no other source sets a status bit or wakes the supply; a button press still wakes it.
- R11: With the supply off, the condition of R6 requests the supply. Writing a one to control bit 3 drops the supply. Control bit 4 reads back the supply state (1 = on).
- R12: A porEvent requests the supply and sets status A bit 10 when control bit 1 (wake-enable) is set, or when the supply was on and control bit 2 (force-off) is clear. Otherwise the supply stays off and bit 10 stays clear.
- R13: A porEvent clears every status bit except bit 10. It leaves the enable, edge-select and control configuration unchanged.
- R14: After cold reset, all registers read 0, pmeN and psOnN are high and smiOut and sciOut are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| coldRstN | input | 1 | Cold reset, active low, clears all state |
| porEvent | input | 1 | One-cycle strobe: a standby power-on reset occurred |
| ringN | input | 2 | Ring-indicator lines, active low |
| kbdData | input | 1 | Keyboard data line |
| mouseData | input | 1 | Mouse data line |
| gpioIn | input | NGPIO | GPIO wake pins |
| keyMatch | input | 1 | One-cycle strobe: wake key detected |
| rtcAlarm | input | 1 | One-cycle strobe: RTC alarm |
| fanEvent | input | 1 | One-cycle strobe: fan-tachometer event |
| pwrBtnN | input | 1 | Power button, active low |
| smiSrc | input | NSMI | Legacy SMI-only interrupt sources |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWData | input | 16 | Register write data |
| regRData | output | 16 | Register read data for regAddr |
| smiOut | output | 1 | System-management interrupt |
| sciOut | output | 1 | ACPI-style system control interrupt |
| pmeN | output | 1 | Power-management event, active low |
| psOnN | output | 1 | Supply-on request, active low |

## Verification
The assertions assume that external lines are held at each level long enough to pass the synchronizer, and that the strobe inputs are one-cycle synchronous pulses. They also assume that porEvent never coincides with a register write. The stimulus holds each line level for several cycles and spaces every event, write and reset pulse apart. The override is exercised only with a button hold far longer than OVR_HOLD, and the ordinary presses are far shorter. Register reads always happen in cycles with no concurrent write.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int DW = 16;
  localparam int AW = 4;

  // status A bit positions
  localparam int B_RING0 = 0;
  localparam int B_RING1 = 1;
  localparam int B_KBD   = 2;
  localparam int B_MSE   = 3;
  localparam int B_KEY   = 4;
  localparam int B_BTN   = 5;
  localparam int B_OVR   = 6;
  localparam int B_AGG   = 7;
  localparam int B_RTC   = 8;
  localparam int B_FAN   = 9;
  localparam int B_POR   = 10;

  localparam logic [AW-1:0] A_STSA   = 4'd0;
  localparam logic [AW-1:0] A_STSG   = 4'd1;
  localparam logic [AW-1:0] A_PMEEN  = 4'd2;
  localparam logic [AW-1:0] A_OUTEN  = 4'd3;
  localparam logic [AW-1:0] A_EDGE   = 4'd4;
  localparam logic [AW-1:0] A_CTRL   = 4'd5;

  localparam logic [DW-1:0] STSA_MASK  = 16'h07FF;
  localparam logic [DW-1:0] OUTEN_MASK = STSA_MASK & ~(16'h0001 << B_OVR);

  // strobes from control to datapath
  typedef struct packed {
    logic clrA;
    logic clrG;
    logic wrPmeEn;
    logic wrOutEn;
    logic wrEdge;
    logic wrCtrl;
    logic porClr;
    logic porSet;
    logic ovrSet;
  } ctlStrb_t;

  function automatic logic [DW-1:0] pmeEnMask(input int ng);
    logic [DW-1:0] m;
    m = '0;
    m[4:0] = '1;
    for (int i = 0; i < ng; i++) m[8+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= INIT;
      cur  <= INIT;
      prev <= INIT;
    end else begin
      meta <= din;
      cur  <= meta;
      prev <= cur;
    end
  end
endmodule

// File: rtl/wake_dpath.sv
module wake_dpath
  import wake_pkg::*;
#(
  parameter int NGPIO = 8,
  parameter int NSMI  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       ringN,
  input  logic             kbdData,
  input  logic             mouseData,
  input  logic [NGPIO-1:0] gpioIn,
  input  logic             keyMatch,
  input  logic             rtcAlarm,
  input  logic             fanEvent,
  input  logic             pwrBtnN,
  input  logic [NSMI-1:0]  smiSrc,
  input  logic [AW-1:0]    regAddr,
  input  logic [DW-1:0]    regWData,
  input  ctlStrb_t         strb,
  input  logic             supplyOn,
  output logic [DW-1:0]    regRData,
  output logic [DW-1:0]    stsA,
  output logic [DW-1:0]    pmeEn,
  output logic [DW-1:0]    outEn,
  output logic             btnFall,
  output logic             btnLow,
  output logic             pmeCond,
  output logic             legacyHit,
  output logic             acpiMode,
  output logic             porWakeEn,
  output logic             forceOff,
  output logic             ovrSts
);
  localparam int NLINE = 5;
  localparam logic [DW-1:0] PMEEN_MASK = pmeEnMask(NGPIO);

  logic [NLINE-1:0] lnCur, lnPrev, lnFall;
  logic [NGPIO-1:0] gCur, gPrev, gpioHit;
  logic [NGPIO-1:0] stsG, edgeSel, setG, clrG;
  logic [NSMI-1:0]  smiEn;
  logic [4:0]       srcRaw;
  logic [DW-1:0]    setA, clrA;

  // index 0,1 ring; 2 kbd; 3 mouse; 4 button (all idle high)
  wake_sync #(.W(NLINE), .INIT({NLINE{1'b1}})) uLineSync (
    .clk(clk), .rstN(rstN),
    .din({pwrBtnN, mouseData, kbdData, ringN}),
    .cur(lnCur), .prev(lnPrev)
  );

  wake_sync #(.W(NGPIO), .INIT({NGPIO{1'b0}})) uGpioSync (
    .clk(clk), .rstN(rstN), .din(gpioIn), .cur(gCur), .prev(gPrev)
  );

  assign lnFall  = lnPrev & ~lnCur;
  assign btnFall = lnFall[4];
  assign btnLow  = ~lnCur[4];
  assign srcRaw  = {keyMatch, lnFall[3:0]};
  assign ovrSts  = stsA[B_OVR];

  for (genvar i = 0; i < NGPIO; i++) begin : gEdge
    assign gpioHit[i] = edgeSel[i] ? (gCur[i] & ~gPrev[i]) : (gPrev[i] & ~gCur[i]);
  end

  always_comb begin
    setA = '0;
    setA[4:0]   = srcRaw & {5{~ovrSts}};
    setA[B_BTN] = btnFall;
    setA[B_OVR] = strb.ovrSet;
    setA[B_AGG] = ~ovrSts & ((|(srcRaw & pmeEn[4:0])) | (|(gpioHit & pmeEn[8 +: NGPIO])));
    setA[B_RTC] = rtcAlarm & ~ovrSts;
    setA[B_FAN] = fanEvent & ~ovrSts;
    clrA = strb.clrA ? regWData : '0;
    setG = gpioHit & {NGPIO{~ovrSts}};
    clrG = strb.clrG ? regWData[NGPIO-1:0] : '0;
  end

  // status: cleared by standby reset, set wins over write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsA <= '0;
      stsG <= '0;
    end else if (strb.porClr) begin
      stsA <= strb.porSet ? (DW'(1) << B_POR) : '0;
      stsG <= '0;
    end else begin
      stsA <= ((stsA & ~clrA) | setA) & STSA_MASK;
      stsG <= (stsG & ~clrG) | setG;
    end
  end

  // configuration: retained across standby reset, cold reset only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pmeEn     <= '0;
      outEn     <= '0;
      edgeSel   <= '0;
      acpiMode  <= 1'b0;
      porWakeEn <= 1'b0;
      forceOff  <= 1'b0;
      smiEn     <= '0;
    end else begin
      if (strb.wrPmeEn) pmeEn   <= regWData & PMEEN_MASK;
      if (strb.wrOutEn) outEn   <= regWData & OUTEN_MASK;
      if (strb.wrEdge)  edgeSel <= regWData[NGPIO-1:0];
      if (strb.wrCtrl) begin
        acpiMode  <= regWData[0];
        porWakeEn <= regWData[1];
        forceOff  <= regWData[2];
        smiEn     <= regWData[8 +: NSMI];
      end
    end
  end

  assign pmeCond   = |(stsA & outEn);
  assign legacyHit = |(smiSrc & smiEn);

  always_comb begin
    regRData = '0;
    case (regAddr)
      A_STSA:  regRData = stsA;
      A_STSG:  regRData[NGPIO-1:0] = stsG;
      A_PMEEN: regRData = pmeEn;
      A_OUTEN: regRData = outEn;
      A_EDGE:  regRData[NGPIO-1:0] = edgeSel;
      A_CTRL: begin
        regRData[0] = acpiMode;
        regRData[1] = porWakeEn;
        regRData[2] = forceOff;
        regRData[4] = supplyOn;
        regRData[8 +: NSMI] = smiEn;
      end
      default: regRData = '0;
    endcase
  end
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int OVR_HOLD = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  input  logic          goBit,
  input  logic          porEvent,
  input  logic          btnFall,
  input  logic          btnLow,
  input  logic          pmeCond,
  input  logic          legacyHit,
  input  logic          acpiMode,
  input  logic          porWakeEn,
  input  logic          forceOff,
  input  logic          ovrSts,
  output ctlStrb_t      strb,
  output logic          supplyOn,
  output logic          smiOut,
  output logic          sciOut,
  output logic          pmeN
);
  localparam int CW = $clog2(OVR_HOLD + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(OVR_HOLD - 1);

  logic [CW-1:0] holdCnt;
  logic          trip, goOff, porWake, onNext;

  assign trip    = supplyOn & btnLow & (holdCnt == HOLD_LAST);
  assign goOff   = regWrEn & (regAddr == A_CTRL) & goBit;
  // supplyOn is retained through the standby reset and reflects the pre-loss state
  assign porWake = porWakeEn | (supplyOn & ~forceOff);

  always_comb begin
    strb.clrA    = regWrEn & (regAddr == A_STSA);
    strb.clrG    = regWrEn & (regAddr == A_STSG);
    strb.wrPmeEn = regWrEn & (regAddr == A_PMEEN);
    strb.wrOutEn = regWrEn & (regAddr == A_OUTEN);
    strb.wrEdge  = regWrEn & (regAddr == A_EDGE);
    strb.wrCtrl  = regWrEn & (regAddr == A_CTRL);
    strb.porClr  = porEvent;
    strb.porSet  = porEvent & porWake;
    strb.ovrSet  = trip & ~porEvent;
  end

  always_comb begin
    if (porEvent)      onNext = porWake;
    else if (supplyOn) onNext = ~(trip | goOff);
    else               onNext = btnFall | (~ovrSts & pmeCond);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      supplyOn <= 1'b0;
      holdCnt  <= '0;
      smiOut   <= 1'b0;
      sciOut   <= 1'b0;
      pmeN     <= 1'b1;
    end else begin
      supplyOn <= onNext;
      if (porEvent | ~supplyOn | ~btnLow | trip) holdCnt <= '0;
      else                                       holdCnt <= holdCnt + 1'b1;
      smiOut <= (~acpiMode & pmeCond) | legacyHit;
      sciOut <= acpiMode & pmeCond;
      pmeN   <= ~pmeCond;
    end
  end
endmodule

// File: rtl/wake_event_hub.sv
module wake_event_hub
  import wake_pkg::*;
#(
  parameter int NGPIO    = 8,
  parameter int NSMI     = 8,
  parameter int OVR_HOLD = 64
) (
  input  logic             clk,
  input  logic             coldRstN,
  input  logic             porEvent,
  input  logic [1:0]       ringN,
  input  logic             kbdData,
  input  logic             mouseData,
  input  logic [NGPIO-1:0] gpioIn,
  input  logic             keyMatch,
  input  logic             rtcAlarm,
  input  logic             fanEvent,
  input  logic             pwrBtnN,
  input  logic [NSMI-1:0]  smiSrc,
  input  logic             regWrEn,
  input  logic [3:0]       regAddr,
  input  logic [15:0]      regWData,
  output logic [15:0]      regRData,
  output logic             smiOut,
  output logic             sciOut,
  output logic             pmeN,
  output logic             psOnN
);
  ctlStrb_t      strb;
  logic [DW-1:0] stsA, pmeEn, outEn;
  logic          btnFall, btnLow, pmeCond, legacyHit;
  logic          acpiMode, porWakeEn, forceOff, ovrSts, supplyOn;

  wake_dpath #(.NGPIO(NGPIO), .NSMI(NSMI)) uDpath (
    .clk(clk), .rstN(coldRstN),
    .ringN(ringN), .kbdData(kbdData), .mouseData(mouseData), .gpioIn(gpioIn),
    .keyMatch(keyMatch), .rtcAlarm(rtcAlarm), .fanEvent(fanEvent),
    .pwrBtnN(pwrBtnN), .smiSrc(smiSrc),
    .regAddr(regAddr), .regWData(regWData), .strb(strb), .supplyOn(supplyOn),
    .regRData(regRData), .stsA(stsA), .pmeEn(pmeEn), .outEn(outEn),
    .btnFall(btnFall), .btnLow(btnLow), .pmeCond(pmeCond), .legacyHit(legacyHit),
    .acpiMode(acpiMode), .porWakeEn(porWakeEn), .forceOff(forceOff), .ovrSts(ovrSts)
  );

  wake_ctrl #(.OVR_HOLD(OVR_HOLD)) uCtrl (
    .clk(clk), .rstN(coldRstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .goBit(regWData[3]),
    .porEvent(porEvent), .btnFall(btnFall), .btnLow(btnLow),
    .pmeCond(pmeCond), .legacyHit(legacyHit), .acpiMode(acpiMode),
    .porWakeEn(porWakeEn), .forceOff(forceOff), .ovrSts(ovrSts),
    .strb(strb), .supplyOn(supplyOn),
    .smiOut(smiOut), .sciOut(sciOut), .pmeN(pmeN)
  );

  assign psOnN = ~supplyOn;
endmodule

// File: rtl/wake_event_hub_chk.sv
module wake_event_hub_chk (
  input logic        clk,
  input logic        rstN,
  input logic        porEvent,
  input logic        btnFall,
  input logic        psOnN,
  input logic [15:0] stsA,
  input logic [15:0] pmeEn,
  input logic [15:0] outEn,
  input logic        acpiMode,
  input logic        porWakeEn,
  input logic        sciOut,
  input logic        pmeN
);
  a_r10_override_offs: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsA[6]) |-> psOnN);

  a_r10_lock_no_wake: assert property (@(posedge clk) disable iff (!rstN)
    (stsA[6] && psOnN && !btnFall && !porEvent) |=> psOnN);

  a_r3_agg_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsA[7]) |-> ($past(pmeEn) != 16'h0));

  a_r13_por_clears: assert property (@(posedge clk) disable iff (!rstN)
    porEvent |=> (stsA[9:0] == 10'h0));

  a_r6_pme_source: assert property (@(posedge clk) disable iff (!rstN)
    !pmeN |-> ($past(stsA & outEn) != 16'h0));

  a_r7_sci_mode: assert property (@(posedge clk) disable iff (!rstN)
    sciOut |-> $past(acpiMode));

  a_r9_btn_wake: assert property (@(posedge clk) disable iff (!rstN)
    (btnFall && psOnN && !porEvent) |=> !psOnN);

  a_r12_por_stays_off: assert property (@(posedge clk) disable iff (!rstN)
    (porEvent && psOnN && !porWakeEn) |=> psOnN);
endmodule

bind wake_event_hub wake_event_hub_chk uChk (
  .clk(clk), .rstN(coldRstN), .porEvent(porEvent), .btnFall(btnFall),
  .psOnN(psOnN), .stsA(stsA), .pmeEn(pmeEn), .outEn(outEn),
  .acpiMode(acpiMode), .porWakeEn(porWakeEn), .sciOut(sciOut), .pmeN(pmeN)
);

// File: tb/sim_wake_event_hub.sv
`timescale 1ns/1ps
module sim_wake_event_hub;
  localparam int NG = 8;
  localparam int NS = 8;
  localparam int HOLD = 64;
  localparam int K_REG = 0, K_PME = 1, K_SMI = 2, K_SCI = 3, K_PSON = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          coldRstN = 1'b0;
  logic          porEvent = 1'b0;
  logic [3:0]    lowLines = 4'hF;
  logic [NG-1:0] gpioIn = '0;
  logic          keyMatch = 1'b0, rtcAlarm = 1'b0, fanEvent = 1'b0, pwrBtnN = 1'b1;
  logic [NS-1:0] smiSrc = '0;
  logic          regWrEn = 1'b0;
  logic [3:0]    regAddr = '0;
  logic [15:0]   regWData = '0;
  logic [15:0]   regRData;
  logic          smiOut, sciOut, pmeN, psOnN;

  wake_event_hub #(.NGPIO(NG), .NSMI(NS), .OVR_HOLD(HOLD)) u0 (
    .clk(clk), .coldRstN(coldRstN), .porEvent(porEvent),
    .ringN(lowLines[1:0]), .kbdData(lowLines[2]), .mouseData(lowLines[3]),
    .gpioIn(gpioIn), .keyMatch(keyMatch), .rtcAlarm(rtcAlarm), .fanEvent(fanEvent),
    .pwrBtnN(pwrBtnN), .smiSrc(smiSrc),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWData(regWData), .regRData(regRData),
    .smiOut(smiOut), .sciOut(sciOut), .pmeN(pmeN), .psOnN(psOnN)
  );

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] ctl = '0;

  // monitor: compares queued expectations away from the active edge
  initial begin : monitor
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] obs;
        it = q.pop_front();
        case (it.kind)
          K_REG:   obs = regRData;
          K_PME:   obs = {15'h0, pmeN};
          K_SMI:   obs = {15'h0, smiOut};
          K_SCI:   obs = {15'h0, sciOut};
          default: obs = {15'h0, psOnN};
        endcase
        checks++;
        if (obs !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, obs, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic expectv(input int kind, input logic [3:0] addr, input logic [15:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    regAddr = addr;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic wr(input logic [3:0] addr, input logic [15:0] d);
    @(posedge clk); #1;
    regAddr = addr; regWData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic dip(input int i);
    @(posedge clk); #1 lowLines[i] = 1'b0;
    idle(5);
    #1 lowLines[i] = 1'b1;
    idle(5);
  endtask

  task automatic press(input int n);
    @(posedge clk); #1 pwrBtnN = 1'b0;
    idle(n);
    #1 pwrBtnN = 1'b1;
    idle(6);
  endtask

  task automatic setGpio(input int i, input logic v);
    @(posedge clk); #1 gpioIn[i] = v;
    idle(6);
  endtask

  task automatic por();
    @(posedge clk); #1 porEvent = 1'b1;
    @(posedge clk); #1 porEvent = 1'b0;
    idle(4);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin : driver
    idle(3);
    #1 coldRstN = 1'b1;
    idle(2);
    // R14 reset state
    expectv(K_REG, 4'd0, 16'h0000, "R14 status A after reset");
    expectv(K_REG, 4'd5, 16'h0000, "R14 control after reset");
    expectv(K_PME, 4'd0, 16'h0001, "R14 pmeN idle");
    expectv(K_PSON, 4'd0, 16'h0001, "R14 psOnN idle");
    expectv(K_SMI, 4'd0, 16'h0000, "R14 smiOut idle");

    // R9 button wakes from off
    press(3);
    expectv(K_PSON, 4'd0, 16'h0000, "R9 button press wakes supply");
    expectv(K_REG, 4'd0, 16'h0020, "R9 button status bit 5");
    expectv(K_REG, 4'd5, 16'h0010, "R11 control bit 4 shows supply on");
    wr(4'd0, 16'h0000);
    expectv(K_REG, 4'd0, 16'h0020, "R5 writing zero keeps status");
    wr(4'd0, 16'h0020);
    expectv(K_REG, 4'd0, 16'h0000, "R5 write one clears status");

    // R1 line edges
    dip(0);
    expectv(K_REG, 4'd0, 16'h0001, "R1 ring0 edge");
    expectv(K_PME, 4'd0, 16'h0001, "R6 no output enable keeps pmeN high");
    dip(2);
    dip(3);
    @(posedge clk); #1 keyMatch = 1'b1;
    @(posedge clk); #1 keyMatch = 1'b0;
    idle(2);
    expectv(K_REG, 4'd0, 16'h001D, "R1 kbd mouse key edges");
    dip(1);
    expectv(K_REG, 4'd0, 16'h001F, "R1 ring1 edge");
    wr(4'd0, 16'hFFFF);
    expectv(K_REG, 4'd0, 16'h0000, "R5 clear all status");

    // R3 aggregate
    wr(4'd2, 16'h0004);
    dip(3);
    expectv(K_REG, 4'd0, 16'h0008, "R3 disabled source no aggregate");
    dip(2);
    expectv(K_REG, 4'd0, 16'h008C, "R3 enabled source sets aggregate");
    wr(4'd0, 16'h008C);

    // R2 gpio polarity
    wr(4'd4, 16'h0001);
    setGpio(0, 1'b1);
    expectv(K_REG, 4'd1, 16'h0001, "R2 rising pin0");
    setGpio(1, 1'b1);
    expectv(K_REG, 4'd1, 16'h0001, "R2 rising ignored on falling pin1");
    setGpio(1, 1'b0);
    setGpio(0, 1'b0);
    expectv(K_REG, 4'd1, 16'h0003, "R2 falling pin1 set, falling pin0 ignored");
    expectv(K_REG, 4'd0, 16'h0000, "R3 gpio not enabled no aggregate");
    wr(4'd1, 16'h0003);
    wr(4'd2, 16'h0100);
    setGpio(0, 1'b1);
    expectv(K_REG, 4'd0, 16'h0080, "R3 gpio enabled sets aggregate");
    wr(4'd1, 16'h0001);
    wr(4'd0, 16'h0080);
    setGpio(0, 1'b0);
    expectv(K_REG, 4'd1, 16'h0000, "R5 gpio status cleared");

    // R4 rtc / fan never aggregate
    wr(4'd2, 16'hFFFF);
    expectv(K_REG, 4'd2, 16'hFF1F, "R3 enable register implemented bits");
    @(posedge clk); #1 rtcAlarm = 1'b1;
    @(posedge clk); #1 rtcAlarm = 1'b0;
    idle(2);
    expectv(K_REG, 4'd0, 16'h0100, "R4 rtc bit 8 without aggregate");
    @(posedge clk); #1 fanEvent = 1'b1;
    @(posedge clk); #1 fanEvent = 1'b0;
    idle(2);
    expectv(K_REG, 4'd0, 16'h0300, "R4 fan bit 9 without aggregate");

    // R6 / R7
    wr(4'd3, 16'h0100);
    expectv(K_PME, 4'd0, 16'h0000, "R6 enabled rtc status drives pmeN low");
    expectv(K_SMI, 4'd0, 16'h0001, "R7 mode 0 raises smi");
    expectv(K_SCI, 4'd0, 16'h0000, "R7 mode 0 no sci");
    ctl = 16'h0001;
    wr(4'd5, ctl);
    idle(1);
    expectv(K_SCI, 4'd0, 16'h0001, "R7 mode 1 raises sci");
    expectv(K_SMI, 4'd0, 16'h0000, "R7 mode 1 no smi");
    wr(4'd0, 16'h0300);
    idle(1);
    expectv(K_PME, 4'd0, 16'h0001, "R6 cleared status releases pmeN");
    expectv(K_SCI, 4'd0, 16'h0000, "R7 sci drops after clear");
    ctl = 16'h0000;
    wr(4'd5, ctl);
    wr(4'd3, 16'h0000);

    // R11 go off, R8 legacy while off
    wr(4'd5, ctl | 16'h0008);
    idle(1);
    expectv(K_PSON, 4'd0, 16'h0001, "R11 control bit 3 drops supply");
    ctl = 16'h0400;
    wr(4'd5, ctl);
    @(posedge clk); #1 smiSrc = 8'h04;
    idle(3);
    expectv(K_SMI, 4'd0, 16'h0001, "R8 enabled legacy source raises smi");
    expectv(K_REG, 4'd0, 16'h0000, "R8 legacy source sets no status");
    expectv(K_PSON, 4'd0, 16'h0001, "R8 legacy source does not wake");
    #1 smiSrc = 8'h02;
    idle(3);
    expectv(K_SMI, 4'd0, 16'h0000, "R8 disabled legacy source no smi");
    #1 smiSrc = 8'h00;

    // R11 wake from enabled status
    wr(4'd3, 16'h0004);
    dip(2);
    expectv(K_PSON, 4'd0, 16'h0000, "R11 enabled kbd status wakes supply");
    expectv(K_PME, 4'd0, 16'h0000, "R6 kbd status with output enable");
    wr(4'd0, 16'h0084);
    idle(1);

    // R10 override
    press(HOLD + 6);
    expectv(K_PSON, 4'd0, 16'h0001, "R10 long hold drops supply");
    expectv(K_REG, 4'd0, 16'h0060, "R10 override bit 6 and button bit 5");
    dip(2);
    expectv(K_REG, 4'd0, 16'h0060, "R10 kbd ignored under lock");
    expectv(K_PSON, 4'd0, 16'h0001, "R10 no wake under lock");
    press(3);
    expectv(K_PSON, 4'd0, 16'h0000, "R10 button wakes under lock");
    wr(4'd0, 16'h0060);
    expectv(K_REG, 4'd0, 16'h0000, "R5 override cleared");

    // R12 / R13 standby reset policy
    ctl = 16'h0000;
    wr(4'd5, ctl);
    dip(3);
    por();
    expectv(K_PSON, 4'd0, 16'h0000, "R12 was on and not forced off rewakes");
    expectv(K_REG, 4'd0, 16'h0400, "R13 reset keeps only bit 10");
    expectv(K_REG, 4'd2, 16'hFF1F, "R13 pme enable retained");
    expectv(K_REG, 4'd3, 16'h0004, "R13 output enable retained");
    expectv(K_REG, 4'd4, 16'h0001, "R13 edge select retained");
    wr(4'd0, 16'h0400);
    wr(4'd5, ctl | 16'h0008);
    idle(1);
    por();
    expectv(K_PSON, 4'd0, 16'h0001, "R12 was off stays off");
    expectv(K_REG, 4'd0, 16'h0000, "R12 no bit 10 without wake");
    ctl = 16'h0004;
    wr(4'd5, ctl);
    press(3);
    wr(4'd0, 16'h0020);
    por();
    expectv(K_PSON, 4'd0, 16'h0001, "R12 force-off blocks rewake");
    expectv(K_REG, 4'd0, 16'h0000, "R12 force-off no bit 10");
    ctl = 16'h0006;
    wr(4'd5, ctl);
    por();
    expectv(K_PSON, 4'd0, 16'h0000, "R12 wake-enable rewakes");
    expectv(K_REG, 4'd0, 16'h0400, "R12 wake-enable sets bit 10");
    expectv(K_REG, 4'd5, 16'h0016, "R13 control retained, on shown");

    idle(2);
    done = 1'b1;
    idle(2);
    summary();
    $finish;
  end
endmodule